// File: doc/BRIEF.md
# Memory Response Inhibit Controller

This block is the memory-side response controller of a snoopy bus whose address and data phases are split. When a read or read-exclusive request appears in the address phase, the controller starts a line fetch from memory in the same cycle. It does not wait to learn whether a cache owns a dirty copy. The snoop outcome arrives a fixed number of cycles after the request, on two wired-OR lines: an inhibit line, which any cache may hold high to keep memory off the data bus, and a modified line.

After the snoop cycle, the controller waits for the inhibit line to be low. It then reads the modified line. If the modified line is low, memory owns the response: it requests the data bus once the fetched line is held, and drives the line with the request tag when it is granted. If the modified line is high, memory cancels its own response and throws away the fetched data. For a plain read it also takes the line that the owning cache puts on the data bus and writes it to memory. For a read-exclusive request it does not write the line back.

The controller handles one transaction at a time. A fetch that returns after a cancel is discarded. No new request is accepted until that fetch has returned.

Top module: `memresp_ctrl`

## Requirements
- R1: A request with `req_cmd` 2'b01 (read) or 2'b10 (read-exclusive), seen while the controller is idle and no fetch is outstanding, raises `mem_rd_req` in that same cycle, with `mem_rd_addr` equal to `req_addr`.
- R2: The snoop outcome is first sampled in cycle `SNOOP_DLY` after the request cycle (request in cycle 0, default sample in cycle 5). The modified line has no effect in earlier cycles.
- R3: `dbus_drv` is never high while the inhibit line is high. It is never high before the cycle after resolution, even when the fetch finished long before.
- R4: Resolution happens in the first cycle, at or after the snoop cycle, in which the inhibit line is low. In that cycle the modified line decides between responding and cancelling.
- R5: On a read resolved with the modified line high, the controller raises `mem_wr_en` in the cycle in which `dbus_in_vld` is high with `dbus_in_tag` equal to the request tag. In that cycle `mem_wr_addr` is the request address and `mem_wr_data` is `dbus_in_data`. Beats that carry another tag are ignored. This cycle may be the resolution cycle itself.
- R6: On resolution with the modified line low, `dbus_req` rises in the first cycle after resolution in which the fetched line is held. `dbus_drv` is high for exactly one cycle, the first cycle in which `dbus_gnt` is high while `dbus_req` is high. During that cycle `dbus_out_data` is the fetched line and `dbus_out_tag` is the request tag.
- R7: A read-exclusive request resolved with the modified line high produces no `dbus_drv` and no `mem_wr_en`.
- R8: After a cancel, fetched data is dropped, including data that returns later. It never reaches the data bus.
- R9: Requests that arrive while a transaction or a fetch is outstanding are ignored: `mem_rd_req` stays low. Commands 2'b00 and 2'b11 are ignored at all times and lead to no bus request.
- R10: After reset, `mem_rd_req`, `mem_wr_en`, `dbus_req` and `dbus_drv` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address-phase request present |
| req_cmd | input | 2 | Command: 01 read, 10 read-exclusive, others ignored |
| req_tag | input | TW | Transaction tag |
| req_addr | input | AW | Line address |
| inhibit_in | input | 1 | Wired-OR inhibit line |
| modified_in | input | 1 | Wired-OR modified line |
| mem_rd_req | output | 1 | Start line fetch |
| mem_rd_addr | output | AW | Fetch address |
| mem_rd_vld | input | 1 | Fetch data returned |
| mem_rd_data | input | DW | Fetched line |
| mem_wr_en | output | 1 | Writeback strobe |
| mem_wr_addr | output | AW | Writeback address |
| mem_wr_data | output | DW | Writeback line |
| dbus_req | output | 1 | Data bus request |
| dbus_gnt | input | 1 | Data bus grant |
| dbus_drv | output | 1 | Memory drives the data bus this cycle |
| dbus_out_tag | output | TW | Tag driven with the line |
| dbus_out_data | output | DW | Line driven by memory |
| dbus_in_vld | input | 1 | A cache drives the data bus |
| dbus_in_tag | input | TW | Tag on the data bus |
| dbus_in_data | input | DW | Line on the data bus |

## Verification
The bench sweeps a grid of cases. It covers both read commands, with and without a stretched inhibit, with the modified line low or high at resolution, and with fetch latencies that end before, at and after resolution. Grants are either immediate or late. Writebacks arrive either in the resolution cycle or later, with a wrong-tag beat first. When the fetch ends early, the grid tells a correct controller from one that drives too soon. When the fetch ends late, it tells a correct controller from one that loses the request. Noise on the modified line before the snoop cycle separates a correct sampling point from an early one. The read-exclusive cases with a late fetch show whether stale data is dropped and whether a new request is blocked until the fetch has returned.

// File: rtl/memresp_pkg.sv
package memresp_pkg;

  localparam logic [1:0] CMD_READ  = 2'b01;
  localparam logic [1:0] CMD_READX = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SNOOP,
    ST_HOLD,
    ST_RESP,
    ST_CAPT
  } resp_state_t;

  function automatic logic is_read_cmd(input logic [1:0] cmd);
    return (cmd == CMD_READ) || (cmd == CMD_READX);
  endfunction

  // cycle k after the request carries count k-1
  function automatic logic snoop_due(input int unsigned cnt, input int unsigned dly);
    return (cnt + 1) == dly;
  endfunction

endpackage

// File: rtl/memresp_snoop_timer.sv
module memresp_snoop_timer #(
  parameter int DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic due
);
  import memresp_pkg::*;

  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign due = run_q && snoop_due(32'(cnt_q), DLY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (due) run_q <= 1'b0;
      else     cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_DUE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> !due); // R2

endmodule

// File: rtl/memresp_fetch.sv
module memresp_fetch #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rd_vld,
  input  logic [DW-1:0] rd_data,
  input  logic          drop,
  input  logic          consume,
  output logic          busy,
  output logic          have,
  output logic [DW-1:0] data
);
  logic discard_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      have      <= 1'b0;
      discard_q <= 1'b0;
      data      <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      have      <= 1'b0;
      discard_q <= 1'b0;
    end else begin
      if (rd_vld && busy) begin
        busy <= 1'b0;
        if (!discard_q && !drop) begin
          have <= 1'b1;
          data <= rd_data;
        end
        discard_q <= 1'b0;
      end else if (drop && busy) begin
        discard_q <= 1'b1;
      end
      if (drop || consume) have <= 1'b0;
    end
  end

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !have); // R8
  AST_HAVE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    have |-> !busy); // R8

endmodule

// File: rtl/memresp_ctrl.sv
module memresp_ctrl #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int TW        = 4,
  parameter int SNOOP_DLY = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_cmd,
  input  logic [TW-1:0] req_tag,
  input  logic [AW-1:0] req_addr,
  input  logic          inhibit_in,
  input  logic          modified_in,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_vld,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          dbus_req,
  input  logic          dbus_gnt,
  output logic          dbus_drv,
  output logic [TW-1:0] dbus_out_tag,
  output logic [DW-1:0] dbus_out_data,
  input  logic          dbus_in_vld,
  input  logic [TW-1:0] dbus_in_tag,
  input  logic [DW-1:0] dbus_in_data
);
  import memresp_pkg::*;

  localparam int AGW = $clog2(SNOOP_DLY + 2) + 1;

  resp_state_t   state_q, state_d;
  logic [TW-1:0] tag_q;
  logic [AW-1:0] addr_q;
  logic          isx_q;
  logic [AGW-1:0] age_q;

  // named internal events
  logic accept, snoop_due_w, in_window, resolve, cancel, resolve_wb, wb_take;
  logic f_busy, f_have;
  logic [DW-1:0] f_data;

  assign accept      = req_valid && is_read_cmd(req_cmd) && (state_q == ST_IDLE) && !f_busy;
  assign in_window   = ((state_q == ST_SNOOP) && snoop_due_w) || (state_q == ST_HOLD);
  assign resolve     = in_window && !inhibit_in;
  assign cancel      = resolve && modified_in;
  assign resolve_wb  = cancel && !isx_q;
  assign wb_take     = (resolve_wb || (state_q == ST_CAPT)) && dbus_in_vld && (dbus_in_tag == tag_q);

  assign mem_rd_req  = accept;
  assign mem_rd_addr = req_addr;
  assign mem_wr_en   = wb_take;
  assign mem_wr_addr = addr_q;
  assign mem_wr_data = dbus_in_data;

  assign dbus_req      = (state_q == ST_RESP) && f_have && !inhibit_in;
  assign dbus_drv      = dbus_req && dbus_gnt;
  assign dbus_out_tag  = tag_q;
  assign dbus_out_data = f_data;

  memresp_snoop_timer #(.DLY(SNOOP_DLY)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .due   (snoop_due_w)
  );

  memresp_fetch #(.DW(DW)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .rd_vld  (mem_rd_vld),
    .rd_data (mem_rd_data),
    .drop    (cancel),
    .consume (dbus_drv),
    .busy    (f_busy),
    .have    (f_have),
    .data    (f_data)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SNOOP;
      ST_SNOOP: if (snoop_due_w && inhibit_in) state_d = ST_HOLD;
      ST_RESP:  if (dbus_drv) state_d = ST_IDLE;
      ST_CAPT:  if (wb_take) state_d = ST_IDLE;
      default:  state_d = state_q;
    endcase
    if (resolve) begin
      if (!modified_in)  state_d = ST_RESP;
      else if (isx_q)    state_d = ST_IDLE;
      else if (wb_take)  state_d = ST_IDLE;
      else               state_d = ST_CAPT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      addr_q  <= '0;
      isx_q   <= 1'b0;
      age_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        tag_q  <= req_tag;
        addr_q <= req_addr;
        isx_q  <= (req_cmd == CMD_READX);
        age_q  <= AGW'(1);
      end else if ((state_q != ST_IDLE) && (age_q != '1)) begin
        age_q  <= age_q + 1'b1;
      end
    end
  end

  AST_FETCH_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> f_busy); // R1
  AST_SNOOP_AGE: assert property (@(posedge clk) disable iff (!rst_n)
    resolve |-> (32'(age_q) >= SNOOP_DLY)); // R2
  AST_DRIVE_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_drv |-> (32'(age_q) > SNOOP_DLY)); // R3
  AST_HOLD_WHILE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && inhibit_in) |=> (state_q == ST_HOLD)); // R4
  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_drv |=> !dbus_drv); // R6
  AST_NO_WB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !isx_q); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (state_q != ST_IDLE)) |-> !mem_rd_req); // R9

endmodule

// File: tb/memresp_ctrl_tb.sv
module memresp_ctrl_tb_top;
  localparam int AW = 16, DW = 32, TW = 4, SN = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [TW-1:0] req_tag = '0;
  logic [AW-1:0] req_addr = '0;
  logic inhibit_in = 1'b0, modified_in = 1'b0;
  logic mem_rd_req, mem_wr_en, dbus_req, dbus_drv;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic mem_rd_vld = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic [DW-1:0] mem_wr_data, dbus_out_data;
  logic dbus_gnt = 1'b0;
  logic [TW-1:0] dbus_out_tag;
  logic dbus_in_vld = 1'b0;
  logic [TW-1:0] dbus_in_tag = '0;
  logic [DW-1:0] dbus_in_data = '0;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  memresp_ctrl #(.AW(AW), .DW(DW), .TW(TW), .SNOOP_DLY(SN)) dut_i (.*);

  function automatic logic [DW-1:0] mem_pat(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction
  function automatic logic [DW-1:0] wb_pat(input logic [AW-1:0] a);
    return {~a, a ^ 16'h3C3C};
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic idle_inputs();
    req_valid = 0; req_cmd = 0; inhibit_in = 0; modified_in = 0;
    mem_rd_vld = 0; dbus_gnt = 0; dbus_in_vld = 0;
  endtask

  // one transaction, cycle 0 = request cycle
  task automatic run_case(input logic [1:0] cmd, input int lat, input bit inh,
                          input bit mod, input int wbd, input int gate,
                          input logic [TW-1:0] tag, input logic [AW-1:0] addr);
    int r, exp_drv_k, last_k, blk_k;
    bit isx;
    isx = (cmd == 2'b10);
    r = inh ? SN + 2 : SN;
    exp_drv_k = mod ? -1 : imax(imax(r + 1, lat + 1), gate);
    blk_k = (mod && lat > r + wbd + 1) ? lat - 1 : -1;
    last_k = imax(imax(lat, r + wbd), exp_drv_k) + 3;
    for (int k = 0; k <= last_k; k++) begin
      @(negedge clk);
      req_valid = (k == 0) || (k == 2) || (k == blk_k);
      req_cmd   = (k == 0) ? cmd : 2'b01;
      req_tag   = (k == 0) ? tag : tag + 1'b1;
      req_addr  = (k == 0) ? addr : addr + 1'b1;
      mem_rd_vld  = (k == lat);
      mem_rd_data = mem_pat(addr);
      inhibit_in  = inh && (k >= SN) && (k < r);
      modified_in = mod ? ((k >= r) && (k <= r + wbd)) : ((k >= 1) && (k < SN));
      dbus_in_vld  = mod && ((k == r + wbd) || (wbd > 0 && k == r));
      dbus_in_tag  = (k == r + wbd) ? tag : tag ^ 4'h1;
      dbus_in_data = wb_pat(addr);
      #1;
      dbus_gnt = dbus_req && (k >= gate);
      #1;
      if (k == 0) begin
        chk(mem_rd_req, "R1", "fetch start", mem_rd_req, 1);
        chk(mem_rd_addr == addr, "R1", "fetch addr", mem_rd_addr, addr);
      end
      if (k == 2 || k == blk_k)
        chk(!mem_rd_req, "R9", "busy request ignored", mem_rd_req, 0);
      if (inhibit_in)
        chk(!dbus_drv, "R3", "drive under inhibit", dbus_drv, 0);
      if (mod)
        chk(dbus_drv == 1'b0, isx ? "R7" : "R8", "no memory drive after cancel", dbus_drv, 0);
      else
        chk(dbus_drv == (k == exp_drv_k), (k < exp_drv_k) ? "R2" : "R6", "drive cycle", dbus_drv, (k == exp_drv_k));
      if (!mod && k == exp_drv_k) begin
        chk(dbus_out_data == mem_pat(addr), "R6", "drive data", dbus_out_data, mem_pat(addr));
        chk(dbus_out_tag == tag, "R6", "drive tag", dbus_out_tag, tag);
      end
      if (!mod && k == imax(r + 1, lat + 1))
        chk(dbus_req, "R6", "bus request when data ready", dbus_req, 1);
      if (mod && isx)
        chk(!mem_wr_en, "R7", "no writeback on exclusive", mem_wr_en, 0);
      else
        chk(mem_wr_en == (mod && k == r + wbd), inh ? "R4" : "R5", "writeback cycle", mem_wr_en, (mod && k == r + wbd));
      if (mem_wr_en) begin
        chk(mem_wr_addr == addr, "R5", "writeback addr", mem_wr_addr, addr);
        chk(mem_wr_data == wb_pat(addr), "R5", "writeback data", mem_wr_data, wb_pat(addr));
      end
    end
    @(negedge clk); idle_inputs();
    @(negedge clk);
  endtask

  task automatic ignored_cmd(input logic [1:0] cmd);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      req_valid = (k == 0); req_cmd = cmd; req_addr = 16'h0777;
      #1;
      chk(!mem_rd_req && !dbus_req, "R9", "ignored command", {mem_rd_req, dbus_req}, 0);
    end
    @(negedge clk); idle_inputs();
  endtask

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!mem_rd_req && !mem_wr_en && !dbus_req && !dbus_drv, "R10", "reset outputs",
        {mem_rd_req, mem_wr_en, dbus_req, dbus_drv}, 0);
    ignored_cmd(2'b00);
    ignored_cmd(2'b11);
    for (int c = 0; c < 2; c++)
      for (int inh = 0; inh < 2; inh++)
        for (int mod = 0; mod < 2; mod++)
          for (int li = 0; li < 4; li++)
            for (int w = 0; w < 2; w++)
              for (int g = 0; g < 2; g++) begin
                int lat;
                lat = (li == 0) ? 1 : (li == 1) ? 4 : (li == 2) ? 6 : 9;
                run_case((c == 0) ? 2'b01 : 2'b10, lat, inh[0], mod[0], w * 2, g * 9,
                         4'(idx), 16'(16'h1000 + idx * 3));
                idx++;
              end
    finish_run();
  end

endmodule